// File: doc/BRIEF.md
# Lattice-Distributed 8-Point FFT

This block computes an 8-point complex forward FFT (radix-2, decimation in time) on four small processing nodes arranged as a 2x2 lattice. Each node keeps two complex values in local registers. Eight samples arrive in natural order on a valid/ready stream. They are written into the lattice in bit-reversed order: position p goes to node `p mod 4` in raster order (row 0 left, row 0 right, row 1 left, row 1 right) and to slot `p / 4`.

Three butterfly stages follow, one clock cycle each. In the first stage, nodes trade values with the other node of their row. In the second, they trade with the other node of their column. In the third, both operands already sit in the same node. Each stage halves its results with rounding and saturates them. The eight results then leave on a second valid/ready stream in natural index order, and a one-cycle done pulse closes the frame.

Back-pressure rules: a beat moves only in a cycle where valid and ready are both high. The source may hold `in_valid` high at any time. Beats offered while `in_ready` is low are not taken and have no effect on the frame in progress. The sink may hold `out_ready` low for as long as it likes. While it does, the offered result and its index do not change.

Top module: `fft8_lattice`

## Requirements
- R1: During reset and afterwards, `out_valid` and `done` are low and `in_ready` is high. A frame is exactly eight accepted input beats, taken as sample indices 0 to 7 in arrival order.
- R2: `in_ready` goes low in the cycle after the eighth beat is accepted. It stays low until the done cycle. Input beats offered while it is low are ignored.
- R3: Result k equals (1/8)·Σ x[n]·e^(−j2πnk/8), rounded to an integer, to within 2 LSB on each of the real and imaginary parts.
- R4: Each stage computes a + W·b and a − W·b. Each result is halved by (v + 1) >>> 1, which rounds halves upward. Test case: a frame with only x[0] = (7, −5) gives (1, 0) on all eight outputs.
- R5: Every stage result is saturated to the range −32768 to 32767. Test case: x[0] = (32767, 0), x[4] = (−32768, 0), all other samples zero. The odd results are then (8192, 0) and the even results (0, 0).
- R6: The twiddle factors are Q1.14 constants W^k = cos(2πk/8) − j·sin(2πk/8) for k = 0 to 3. Each product with a twiddle is rounded to nearest (add 2^13, then shift right arithmetically by 14).
- R7: While `out_valid` is high, `out_idx` counts from 0 to 7 and advances only on a cycle with `out_ready` high. While the sink stalls, index and data stay unchanged.
- R8: `done` is high for exactly one cycle, the cycle after the beat with index 7 is accepted. `in_ready` is high in that same cycle.
- R9: `out_valid` rises at the third rising clock edge after the edge that accepts the eighth input beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Sink takes the result |
| out_idx | output | 3 | Frequency index of the offered result |
| out_re | output | 16 | Result real part, signed |
| out_im | output | 16 | Result imaginary part, signed |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
A sample written to the wrong node or slot, a wrong exchange partner, or a wrong twiddle index does not stay hidden. It puts energy into the wrong output bins. This shows in the first frame whose spectrum is not symmetric, at the first output index involved, four cycles after the last input beat. Rounding and saturation faults are exposed by impulse and extreme-value frames whose outputs are known exactly. A control-state fault shows up as a wrong `in_ready`, `out_valid` or `done` level within a cycle. This is visible because the handshake levels are compared against a model in every cycle, under random input gaps and output stalls.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  localparam int NPTS   = 8;
  localparam int LOGN   = $clog2(NPTS);
  localparam int LAT_W  = 2;
  localparam int NODES  = LAT_W * LAT_W;
  localparam int NB     = $clog2(NODES);
  localparam int SLOTS  = NPTS / NODES;
  localparam int SB     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int DW     = 16;
  localparam int TFRAC  = 14;
  localparam int TW     = TFRAC + 2;
  localparam int PW     = DW + TW + 2;
  localparam int C45    = int'(0.7071067811865476 * (2.0 ** TFRAC));
  localparam int ONE    = 1 << TFRAC;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cplx_t;

  typedef struct packed {
    logic signed [TW-1:0] re;
    logic signed [TW-1:0] im;
  } twid_t;

  typedef enum logic [1:0] {ST_ROW = 2'd0, ST_COL = 2'd1, ST_LOCAL = 2'd2} stage_e;

  function automatic twid_t twiddle(input logic [1:0] k);
    twid_t w;
    case (k)
      2'd0:    begin w.re = TW'(ONE);  w.im = TW'(0);    end
      2'd1:    begin w.re = TW'(C45);  w.im = TW'(-C45); end
      2'd2:    begin w.re = TW'(0);    w.im = TW'(-ONE); end
      default: begin w.re = TW'(-C45); w.im = TW'(-C45); end
    endcase
    return w;
  endfunction

  function automatic logic [LOGN-1:0] bitrev(input logic [LOGN-1:0] v);
    logic [LOGN-1:0] r;
    for (int i = 0; i < LOGN; i++) r[i] = v[LOGN-1-i];
    return r;
  endfunction
endpackage

// File: rtl/fft8_bfly.sv
module fft8_bfly
  import fft8_pkg::*;
(
  input  cplx_t      loc,
  input  cplx_t      par,
  input  logic       upper,
  input  logic [1:0] widx,
  output cplx_t      res
);
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (TFRAC - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(1 << (DW - 1));

  cplx_t x, y;
  twid_t w;
  logic signed [PW-1:0] yr, yi, wr, wi, xr, xi;
  logic signed [PW-1:0] pr, pi, tr, ti, sr, si, hr, hi;

  always_comb begin
    x  = upper ? loc : par;
    y  = upper ? par : loc;
    w  = twiddle(widx);
    yr = PW'(y.re);
    yi = PW'(y.im);
    wr = PW'(w.re);
    wi = PW'(w.im);
    xr = PW'(x.re);
    xi = PW'(x.im);
    pr = yr * wr - yi * wi;
    pi = yr * wi + yi * wr;
    tr = (pr + RND) >>> TFRAC;
    ti = (pi + RND) >>> TFRAC;
    sr = upper ? (xr + tr) : (xr - tr);
    si = upper ? (xi + ti) : (xi - ti);
    hr = (sr + PW'(1)) >>> 1;
    hi = (si + PW'(1)) >>> 1;
    res.re = (hr > MAXV) ? MAXV[DW-1:0] : (hr < MINV) ? MINV[DW-1:0] : hr[DW-1:0];
    res.im = (hi > MAXV) ? MAXV[DW-1:0] : (hi < MINV) ? MINV[DW-1:0] : hi[DW-1:0];
  end
endmodule

// File: rtl/fft8_node.sv
module fft8_node
  import fft8_pkg::*;
#(
  parameter int ROW = 0,
  parameter int COL = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic [SB-1:0]       ld_slot,
  input  cplx_t               ld_data,
  input  logic                stage_en,
  input  stage_e              stage,
  input  cplx_t [SLOTS-1:0]   row_nbr,
  input  cplx_t [SLOTS-1:0]   col_nbr,
  output cplx_t [SLOTS-1:0]   q
);
  localparam int NODE_ID = ROW * LAT_W + COL;

  cplx_t slot_r [SLOTS];
  cplx_t res    [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    cplx_t      par;
    logic       upper;
    logic [1:0] widx;

    always_comb begin
      case (stage)
        ST_ROW: begin
          par = row_nbr[s]; upper = (COL == 0); widx = 2'd0;
        end
        ST_COL: begin
          par = col_nbr[s]; upper = (ROW == 0); widx = 2'(COL * 2);
        end
        default: begin
          par = slot_r[SLOTS-1-s]; upper = (s == 0); widx = 2'(NODE_ID);
        end
      endcase
    end

    fft8_bfly u_bfly (.loc(slot_r[s]), .par(par), .upper(upper), .widx(widx), .res(res[s]));

    assign q[s] = slot_r[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) slot_r[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (ld_en && ld_slot == SB'(s)) slot_r[s] <= ld_data;
        else if (stage_en)              slot_r[s] <= res[s];
      end
    end
  end

  a_r2_load_excludes_stage: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_en && stage_en));
endmodule

// File: rtl/fft8_ctrl.sv
module fft8_ctrl
  import fft8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  output logic            ld_en,
  output logic [LOGN-1:0] ld_pos,
  output logic            stage_en,
  output stage_e          stage,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [LOGN-1:0] out_idx,
  output logic            done
);
  typedef enum logic [1:0] {PH_LOAD, PH_RUN, PH_DRAIN} phase_e;

  localparam logic [LOGN-1:0] LAST_PT = LOGN'(NPTS - 1);
  localparam logic [LOGN-1:0] LAST_ST = LOGN'(LOGN - 1);

  phase_e          ph;
  logic [LOGN-1:0] cnt;
  logic            done_q;

  always_comb begin
    in_ready  = (ph == PH_LOAD);
    ld_en     = in_ready && in_valid;
    ld_pos    = bitrev(cnt);
    stage_en  = (ph == PH_RUN);
    stage     = stage_e'(cnt[1:0]);
    out_valid = (ph == PH_DRAIN);
    out_idx   = cnt;
    done      = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_LOAD;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        PH_LOAD: if (in_valid) begin
          cnt <= (cnt == LAST_PT) ? '0 : cnt + 1'b1;
          if (cnt == LAST_PT) ph <= PH_RUN;
        end
        PH_RUN: begin
          cnt <= (cnt == LAST_ST) ? '0 : cnt + 1'b1;
          if (cnt == LAST_ST) ph <= PH_DRAIN;
        end
        default: if (out_ready) begin
          cnt <= (cnt == LAST_PT) ? '0 : cnt + 1'b1;
          if (cnt == LAST_PT) begin
            ph     <= PH_LOAD;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_idx == LAST_PT));
  a_r8_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx));
  a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_idx != LAST_PT |=> out_valid && out_idx == $past(out_idx) + 1'b1);
  a_r2_ready_falls_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));
endmodule

// File: rtl/fft8_lattice.sv
module fft8_lattice
  import fft8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LOGN-1:0]      out_idx,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 done
);
  logic            ld_en, stage_en;
  logic [LOGN-1:0] ld_pos;
  stage_e          stage;
  cplx_t           ld_data, sel;
  cplx_t [SLOTS-1:0] node_q [NODES];

  fft8_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ld_en(ld_en), .ld_pos(ld_pos), .stage_en(stage_en), .stage(stage),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .done(done)
  );

  assign ld_data.re = in_re;
  assign ld_data.im = in_im;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    fft8_node #(.ROW(n / LAT_W), .COL(n % LAT_W)) u_node (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en && ld_pos[NB-1:0] == NB'(n)),
      .ld_slot(SB'(ld_pos[LOGN-1:NB])),
      .ld_data(ld_data),
      .stage_en(stage_en), .stage(stage),
      .row_nbr(node_q[n ^ 1]),
      .col_nbr(node_q[n ^ LAT_W]),
      .q(node_q[n])
    );
  end

  always_comb begin
    sel    = node_q[out_idx[NB-1:0]][out_idx[LOGN-1:NB]];
    out_re = sel.re;
    out_im = sel.im;
  end

  a_r9_compute_window: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en |-> !in_ready && !out_valid);
endmodule

// File: tb/fft8_lattice_tb.sv
module fft8_lattice_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, done;
  logic [2:0] out_idx;
  logic signed [15:0] out_re, out_im;

  fft8_lattice u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_idx(out_idx), .out_re(out_re), .out_im(out_im), .done(done)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0, stall_en = 1'b0;
  int exp_re [0:15][0:7];
  int exp_im [0:15][0:7];
  int tol [0:15];
  string rq [0:15];
  int frames_sent = 0, frames_done = 0;
  int m_phase = 0, m_cnt = 0, m_busy = 0, m_oidx = 0;
  bit m_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural handshake model, advanced on each rising edge from the inputs only
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_busy = 0; m_oidx = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      case (m_phase)
        0: if (in_valid) begin
          m_cnt++;
          if (m_cnt == 8) begin m_phase = 1; m_busy = 0; end
        end
        1: begin
          m_busy++;
          if (m_busy == 3) begin m_phase = 2; m_oidx = 0; end
        end
        default: if (out_ready) begin
          if (m_oidx == 7) begin m_phase = 0; m_cnt = 0; m_done = 1'b1; frames_done++; end
          else m_oidx++;
        end
      endcase
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_ready == (m_phase == 0), "R2", "in_ready", int'(in_ready), int'(m_phase == 0));
      chk(out_valid == (m_phase == 2), "R9", "out_valid", int'(out_valid), int'(m_phase == 2));
      chk(done == m_done, "R8", "done", int'(done), int'(m_done));
      if (m_phase == 2 && out_valid) begin
        int dr, di;
        chk(int'(out_idx) == m_oidx, "R7", "out_idx", int'(out_idx), m_oidx);
        dr = int'(out_re) - exp_re[frames_done][m_oidx];
        di = int'(out_im) - exp_im[frames_done][m_oidx];
        if (dr < 0) dr = -dr;
        if (di < 0) di = -di;
        chk(dr <= tol[frames_done], rq[frames_done], "out_re",
            int'(out_re), exp_re[frames_done][m_oidx]);
        chk(di <= tol[frames_done], rq[frames_done], "out_im",
            int'(out_im), exp_im[frames_done][m_oidx]);
      end
    end
  end

  always @(negedge clk) out_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;

  task automatic fill_expected(input int re[8], input int im[8], input int tv, input string r);
    real pi = 3.14159265358979;
    for (int k = 0; k < 8; k++) begin
      real sr = 0.0, si = 0.0;
      int er, ei;
      for (int n = 0; n < 8; n++) begin
        real a = -2.0 * pi * n * k / 8.0;
        sr += re[n] * $cos(a) - im[n] * $sin(a);
        si += re[n] * $sin(a) + im[n] * $cos(a);
      end
      er = int'(sr / 8.0);
      ei = int'(si / 8.0);
      exp_re[frames_sent][k] = (er > 32767) ? 32767 : (er < -32768) ? -32768 : er;
      exp_im[frames_sent][k] = (ei > 32767) ? 32767 : (ei < -32768) ? -32768 : ei;
    end
    tol[frames_sent] = tv;
    rq[frames_sent]  = r;
  endtask

  // called at a falling edge; returns at the falling edge after the last beat is taken
  task automatic drive(input int re[8], input int im[8], input bit gaps);
    frames_sent++;
    for (int n = 0; n < 8; n++) begin
      if (gaps && ($urandom % 2 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_re = 16'(re[n]);
      in_im = 16'(im[n]);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R9", "watchdog frames done", frames_done, frames_sent);
      finish_up();
    end
  end

  initial begin
    int re[8], im[8];
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset",
        int'({in_ready, out_valid}), 2);

    // R4: rounding on an impulse, exact result (1,0) everywhere
    for (int n = 0; n < 8; n++) begin re[n] = 0; im[n] = 0; end
    re[0] = 7; im[0] = -5;
    fill_expected(re, im, 0, "R4");
    for (int k = 0; k < 8; k++) begin exp_re[frames_sent][k] = 1; exp_im[frames_sent][k] = 0; end
    drive(re, im, 1'b0);

    // R5: saturation, exact result
    for (int n = 0; n < 8; n++) begin re[n] = 0; im[n] = 0; end
    re[0] = 32767; re[4] = -32768;
    fill_expected(re, im, 0, "R5");
    drive(re, im, 1'b0);

    // R3: constant input
    for (int n = 0; n < 8; n++) begin re[n] = 1000; im[n] = -2000; end
    fill_expected(re, im, 2, "R3");
    drive(re, im, 1'b0);

    // R6: tones that need the odd twiddles
    for (int n = 0; n < 8; n++) begin
      re[n] = int'(8000.0 * $cos(2.0 * 3.14159265358979 * n / 8.0));
      im[n] = int'(8000.0 * $sin(2.0 * 3.14159265358979 * n / 8.0));
    end
    fill_expected(re, im, 2, "R6");
    drive(re, im, 1'b0);
    for (int n = 0; n < 8; n++) begin
      re[n] = int'(6000.0 * $cos(2.0 * 3.14159265358979 * 3 * n / 8.0));
      im[n] = int'(-6000.0 * $sin(2.0 * 3.14159265358979 * 5 * n / 8.0));
    end
    fill_expected(re, im, 2, "R6");
    drive(re, im, 1'b0);

    // R3 / R7 / R2: random frames, with input gaps and output stalls
    stall_en = 1'b1;
    for (int f = 0; f < 6; f++) begin
      for (int n = 0; n < 8; n++) begin
        re[n] = int'($urandom_range(16000)) - 8000;
        im[n] = int'($urandom_range(16000)) - 8000;
      end
      fill_expected(re, im, 2, "R3");
      drive(re, im, f[0]);
    end

    while (frames_done < frames_sent) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule